// File: doc/BRIEF.md
# Real-Mode Address Translation Unit

This unit produces a real address from a 64-bit effective address when address relocation is switched off for the access. It holds three configuration values: a partition control word, a hypervisor real-mode offset and a guest real-mode offset. The control word carries a virtual-real-mode enable flag and a 4-bit size code. From these values, the hypervisor state and the access type, the unit picks one of three paths:

- **Hypervisor path:** the hypervisor offset is applied.
- **Bounded guest path:** the guest offset is applied below a limit decoded from the size code.
- **Virtual-segment path:** the access is passed to the segment translation logic, which lies outside this block.

An access past the guest limit produces a storage fault whose class and status depend on the access type. A request is taken in one cycle. The result appears on the following cycle, qualified by `rsp_valid`.

Top module: `rmx_unit`

## Requirements
- R1: A request is accepted only when relocation is off for its access type. A fetch (`req_kind`=2) checks `ifetch_reloc`, and a load (0) or store (1) checks `data_reloc`. An accepted request gives `rsp_valid`=1 one cycle later. A request with its relocation bit set gives no strobe.
- R2: The four most significant effective address bits never reach `rsp_ra`. The base address is `req_ea` AND 0x0FFF_FFFF_FFFF_FFFF.
- R3: When `hv_state`=1 or `hv_support`=0, `rsp_ra` is the base address ORed with the hypervisor offset if `req_ea[63]`=0, and the bare base address if `req_ea[63]`=1. This path never faults.
- R4: Outside hypervisor state (with hypervisor support), if control bit 0 is set, one of two results follows:
  - with `vseg_page_ok`=1: `rsp_vseg`=1, no fault, and `rsp_ra` equal to the base address;
  - with `vseg_page_ok`=0: a machine-check fault, `rsp_class`=3, `rsp_status`=0 and `rsp_vseg`=0.
- R5: Outside hypervisor state with control bit 0 clear, a base address below the decoded limit gives `rsp_ra` equal to the base ORed with the guest offset, and no fault.
- R6: A guest access at or above the limit faults with `rsp_ra`=0:
  - a fetch gives `rsp_class`=1 and status 0x0800_0000;
  - a load gives `rsp_class`=2 and status 0x0800_0000;
  - a store gives `rsp_class`=2 and status 0x0A00_0000.
- R7: The size code sits in control bits [7:4] and decodes as follows:

  | Code | Limit |
  |------|-------|
  | 0x1 | 16 GB |
  | 0x2 | 1 GB |
  | 0x4 | 256 MB |
  | 0x7 | 128 MB |
  | 0x3 | 64 MB |
  | 0x8 | 32 MB |
  | any other | 0 (every guest access faults) |

- R8: A control word written on one clock edge (`ctl_we`=1) governs a request presented on the very next edge.
- R9: After reset the control word, both offsets and the decoded limit are zero, and `rsp_valid` is 0.
- R10: A request with `req_kind`=3 is ignored and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Partition control word write enable |
| ctl_wdata | input | 8 | Control word: bit 0 virtual-real-mode enable, bits [7:4] size code |
| hoff_we | input | 1 | Hypervisor offset write enable |
| hoff_wdata | input | 64 | Hypervisor offset value |
| goff_we | input | 1 | Guest offset write enable |
| goff_wdata | input | 64 | Guest offset value |
| req_valid | input | 1 | Translation request strobe |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_ea | input | 64 | Effective address |
| hv_state | input | 1 | Processor is in hypervisor state |
| hv_support | input | 1 | Implementation provides hypervisor state |
| ifetch_reloc | input | 1 | Instruction relocation enabled |
| data_reloc | input | 1 | Data relocation enabled |
| vseg_page_ok | input | 1 | Virtual real-mode segment has a valid page-size descriptor |
| rsp_valid | output | 1 | Result strobe, one cycle after an accepted request |
| rsp_ra | output | 64 | Real address (0 on fault) |
| rsp_fault | output | 1 | Access faulted |
| rsp_class | output | 2 | 0 none, 1 instruction storage, 2 data storage, 3 machine check |
| rsp_status | output | 32 | Fault status code |
| rsp_vseg | output | 1 | Access handed to the virtual-segment path |

## Verification
A vector table walks each path with addresses chosen to separate the alternatives:
- **Hypervisor path:** EA bit 63 is set and cleared, and the top nibble is nonzero, which separates the hypervisor offset from the bare masked address.
- **Missing hypervisor support:** a case with `hv_support` low shows that the offset does not depend on hypervisor state alone.
- **Guest path:** each valid size code is paired with an address just below or exactly at its limit, so an off-by-one compare or a swapped decode entry changes the result. An undefined code is also tried.
- **Access types:** fetch, load and store each reach a bounds fault, which separates the three status values.

Directed sequences then cover the zero state after reset, a control write followed at once by a request, reserved access types, and mismatched relocation bits.

// File: rtl/rmx_pkg.sv
package rmx_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      FC_NONE  = 2'd0,
      FC_ISTOR = 2'd1,
      FC_DSTOR = 2'd2,
      FC_MCHK  = 2'd3
   } fault_cls_e;

   localparam logic [31:0] ST_BOUND = 32'h0800_0000;
   localparam logic [31:0] ST_STORE = 32'h0200_0000;

   // Size code to byte limit; undefined codes give zero.
   function automatic logic [63:0] size_decode(input logic [3:0] code);
      logic [63:0] lim;
      case (code)
         4'h1:    lim = 64'h1 << 34;
         4'h2:    lim = 64'h1 << 30;
         4'h4:    lim = 64'h1 << 28;
         4'h7:    lim = 64'h1 << 27;
         4'h3:    lim = 64'h1 << 26;
         4'h8:    lim = 64'h1 << 25;
         default: lim = '0;
      endcase
      return lim;
   endfunction

endpackage

// File: rtl/rmx_ctl_regs.sv
module rmx_ctl_regs
   import rmx_pkg::*;
#(
   parameter int AW        = 64,
   parameter int CW        = 8,
   parameter int VRM_BIT   = 0,
   parameter int SZ_LSB    = 4,
   parameter bit REG_LIMIT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_we,
   input  logic [CW-1:0] ctl_wdata,
   input  logic          hoff_we,
   input  logic [AW-1:0] hoff_wdata,
   input  logic          goff_we,
   input  logic [AW-1:0] goff_wdata,
   output logic          vrm_en,
   output logic [AW-1:0] limit,
   output logic [AW-1:0] hoff,
   output logic [AW-1:0] goff
);

   localparam int CODE_W = 4;

   generate
      if (CW < SZ_LSB + CODE_W || VRM_BIT >= CW) begin : g_bad_cw
         $error("rmx_ctl_regs: control field positions exceed CW");
      end
   endgenerate

   logic [CODE_W-1:0] wr_code;
   logic [63:0]       wr_lim;
   logic              unused_ctl_bits;

   assign wr_code         = ctl_wdata[SZ_LSB +: CODE_W];
   assign wr_lim          = size_decode(wr_code);
   assign unused_ctl_bits = ^ctl_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vrm_en <= 1'b0;
         hoff   <= '0;
         goff   <= '0;
      end else begin
         if (ctl_we)  vrm_en <= ctl_wdata[VRM_BIT];
         if (hoff_we) hoff   <= hoff_wdata;
         if (goff_we) goff   <= goff_wdata;
      end
   end

   generate
      if (REG_LIMIT) begin : g_reg_limit
         // Decode at write time; the compare path sees a flop.
         logic [AW-1:0] limit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      limit_q <= '0;
            else if (ctl_we) limit_q <= wr_lim[AW-1:0];
         end
         assign limit = limit_q;
      end else begin : g_comb_limit
         // Keep the raw code and decode on every access.
         logic [CODE_W-1:0] code_q;
         logic [63:0]       rd_lim;
         always_ff @(posedge clk) begin
            if (!rst_n)      code_q <= '0;
            else if (ctl_we) code_q <= wr_code;
         end
         assign rd_lim = size_decode(code_q);
         assign limit  = rd_lim[AW-1:0];
      end
   endgenerate

   // R7
   bad_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !(wr_code inside {4'h1, 4'h2, 4'h3, 4'h4, 4'h7, 4'h8}))
      |=> (limit == '0));

   // R8
   limit_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && wr_code == 4'h1) |=> (limit == AW'(64'h4_0000_0000)));

endmodule

// File: rtl/rmx_xlate_core.sv
module rmx_xlate_core
   import rmx_pkg::*;
#(
   parameter int AW = 64
) (
   input  logic [1:0]    kind,
   input  logic [AW-1:0] ea,
   input  logic          hv_state,
   input  logic          hv_support,
   input  logic          vrm_en,
   input  logic          page_ok,
   input  logic [AW-1:0] limit,
   input  logic [AW-1:0] hoff,
   input  logic [AW-1:0] goff,
   output logic [AW-1:0] ra,
   output logic          fault,
   output logic [1:0]    cls,
   output logic [31:0]   status,
   output logic          vseg
);

   localparam logic [AW-1:0] EA_MASK = {4'b0000, {(AW-4){1'b1}}};

   logic [AW-1:0] base;
   assign base = ea & EA_MASK;

   always_comb begin
      ra     = base;
      fault  = 1'b0;
      cls    = FC_NONE;
      status = '0;
      vseg   = 1'b0;
      if (hv_state || !hv_support) begin
         if (!ea[AW-1]) ra = base | hoff;
      end else if (vrm_en) begin
         if (page_ok) begin
            vseg = 1'b1;
         end else begin
            ra    = '0;
            fault = 1'b1;
            cls   = FC_MCHK;
         end
      end else if (base < limit) begin
         ra = base | goff;
      end else begin
         ra    = '0;
         fault = 1'b1;
         if (kind == ACC_FETCH) begin
            cls    = FC_ISTOR;
            status = ST_BOUND;
         end else begin
            cls    = FC_DSTOR;
            status = ST_BOUND | ((kind == ACC_STORE) ? ST_STORE : 32'h0);
         end
      end
   end

endmodule

// File: rtl/rmx_unit.sv
module rmx_unit
   import rmx_pkg::*;
#(
   parameter int AW        = 64,
   parameter int CW        = 8,
   parameter int VRM_BIT   = 0,
   parameter int SZ_LSB    = 4,
   parameter bit REG_LIMIT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_we,
   input  logic [CW-1:0] ctl_wdata,
   input  logic          hoff_we,
   input  logic [AW-1:0] hoff_wdata,
   input  logic          goff_we,
   input  logic [AW-1:0] goff_wdata,
   input  logic          req_valid,
   input  logic [1:0]    req_kind,
   input  logic [AW-1:0] req_ea,
   input  logic          hv_state,
   input  logic          hv_support,
   input  logic          ifetch_reloc,
   input  logic          data_reloc,
   input  logic          vseg_page_ok,
   output logic          rsp_valid,
   output logic [AW-1:0] rsp_ra,
   output logic          rsp_fault,
   output logic [1:0]    rsp_class,
   output logic [31:0]   rsp_status,
   output logic          rsp_vseg
);

   generate
      if (AW < 36 || AW > 64) begin : g_bad_aw
         $error("rmx_unit: AW must lie in 36..64");
      end
   endgenerate

   logic          vrm_en;
   logic [AW-1:0] limit, hoff, goff;
   logic [AW-1:0] c_ra;
   logic          c_fault, c_vseg;
   logic [1:0]    c_cls;
   logic [31:0]   c_status;
   logic          reloc_off, accept;

   rmx_ctl_regs #(
      .AW(AW), .CW(CW), .VRM_BIT(VRM_BIT), .SZ_LSB(SZ_LSB), .REG_LIMIT(REG_LIMIT)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .hoff_we(hoff_we), .hoff_wdata(hoff_wdata),
      .goff_we(goff_we), .goff_wdata(goff_wdata),
      .vrm_en(vrm_en), .limit(limit), .hoff(hoff), .goff(goff)
   );

   rmx_xlate_core #(.AW(AW)) core_i (
      .kind(req_kind), .ea(req_ea),
      .hv_state(hv_state), .hv_support(hv_support),
      .vrm_en(vrm_en), .page_ok(vseg_page_ok),
      .limit(limit), .hoff(hoff), .goff(goff),
      .ra(c_ra), .fault(c_fault), .cls(c_cls), .status(c_status), .vseg(c_vseg)
   );

   always_comb begin
      case (req_kind)
         ACC_FETCH:           reloc_off = !ifetch_reloc;
         ACC_LOAD, ACC_STORE: reloc_off = !data_reloc;
         default:             reloc_off = 1'b0;
      endcase
   end
   assign accept = req_valid && reloc_off;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_ra     <= '0;
         rsp_fault  <= 1'b0;
         rsp_class  <= FC_NONE;
         rsp_status <= '0;
         rsp_vseg   <= 1'b0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_ra     <= c_ra;
            rsp_fault  <= c_fault;
            rsp_class  <= c_cls;
            rsp_status <= c_status;
            rsp_vseg   <= c_vseg;
         end
      end
   end

   // R1
   strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_kind != 2'd3));

   // R10
   rsvd_kind_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd3) |=> !rsp_valid);

   // R6
   fetch_bound_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_class == FC_ISTOR) |-> (rsp_status == 32'h0800_0000));

   // R4
   fault_vseg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_fault, rsp_vseg}));

   // R4
   mchk_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_class == FC_MCHK) |-> (rsp_status == 32'h0 && rsp_fault));

   // R3
   hv_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && reloc_off && hv_state) |=> !rsp_fault);

endmodule

// File: tb/rmx_unit_tb.sv
module rmx_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] HOFF = 64'h0000_4000_0000_0000;
   localparam logic [63:0] GOFF = 64'h0000_0080_0000_0000;

   typedef struct packed {
      logic [7:0]  req;
      logic [7:0]  ctl;
      logic        hv;
      logic        hvsup;
      logic        pgok;
      logic [1:0]  kind;
      logic [63:0] ea;
      logic [63:0] xra;
      logic        xfault;
      logic [1:0]  xcls;
      logic [31:0] xst;
      logic        xvseg;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      // R3 hv, bit63 clear: offset applied
      '{8'd3, 8'h00, 1'b1, 1'b1, 1'b0, 2'd0, 64'h0000_0000_0123_4560, 64'h0000_4000_0123_4560, 1'b0, 2'd0, 32'h0, 1'b0},
      // R2 R3 hv, bit63 set: masked, no offset
      '{8'd3, 8'h00, 1'b1, 1'b1, 1'b0, 2'd0, 64'hF000_0000_0000_1000, 64'h0000_0000_0000_1000, 1'b0, 2'd0, 32'h0, 1'b0},
      // R3 no hypervisor support, top nibble 7
      '{8'd3, 8'h00, 1'b0, 1'b0, 1'b0, 2'd2, 64'h7000_0000_0000_2000, 64'h0000_4000_0000_2000, 1'b0, 2'd0, 32'h0, 1'b0},
      // R5 16GB just below
      '{8'd5, 8'h10, 1'b0, 1'b1, 1'b0, 2'd0, 64'h0000_0003_FFFF_FFF0, 64'h0000_0083_FFFF_FFF0, 1'b0, 2'd0, 32'h0, 1'b0},
      // R6 16GB at limit, store
      '{8'd6, 8'h10, 1'b0, 1'b1, 1'b0, 2'd1, 64'h0000_0004_0000_0000, 64'h0, 1'b1, 2'd2, 32'h0A00_0000, 1'b0},
      // R6 32MB at limit, fetch
      '{8'd6, 8'h80, 1'b0, 1'b1, 1'b0, 2'd2, 64'h0000_0000_0200_0000, 64'h0, 1'b1, 2'd1, 32'h0800_0000, 1'b0},
      // R7 32MB just below
      '{8'd7, 8'h80, 1'b0, 1'b1, 1'b0, 2'd0, 64'h0000_0000_01FF_FFFF, 64'h0000_0080_01FF_FFFF, 1'b0, 2'd0, 32'h0, 1'b0},
      // R7 64MB just below
      '{8'd7, 8'h30, 1'b0, 1'b1, 1'b0, 2'd0, 64'h0000_0000_03FF_FFFF, 64'h0000_0080_03FF_FFFF, 1'b0, 2'd0, 32'h0, 1'b0},
      // R7 128MB at limit, store
      '{8'd7, 8'h70, 1'b0, 1'b1, 1'b0, 2'd1, 64'h0000_0000_0800_0000, 64'h0, 1'b1, 2'd2, 32'h0A00_0000, 1'b0},
      // R7 256MB just below
      '{8'd7, 8'h40, 1'b0, 1'b1, 1'b0, 2'd0, 64'h0000_0000_0FFF_FFFF, 64'h0000_0080_0FFF_FFFF, 1'b0, 2'd0, 32'h0, 1'b0},
      // R7 1GB at limit, load
      '{8'd7, 8'h20, 1'b0, 1'b1, 1'b0, 2'd0, 64'h0000_0000_4000_0000, 64'h0, 1'b1, 2'd2, 32'h0800_0000, 1'b0},
      // R7 undefined code 5, address zero
      '{8'd7, 8'h50, 1'b0, 1'b1, 1'b0, 2'd0, 64'h0, 64'h0, 1'b1, 2'd2, 32'h0800_0000, 1'b0},
      // R4 virtual segment, descriptor present
      '{8'd4, 8'h01, 1'b0, 1'b1, 1'b1, 2'd0, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_1234, 1'b0, 2'd0, 32'h0, 1'b1},
      // R4 virtual segment, no descriptor
      '{8'd4, 8'h01, 1'b0, 1'b1, 1'b0, 2'd1, 64'h0000_0000_0000_1234, 64'h0, 1'b1, 2'd3, 32'h0, 1'b0},
      // R2 guest, top nibble discarded before the compare
      '{8'd2, 8'h10, 1'b0, 1'b1, 1'b0, 2'd0, 64'hF000_0000_0000_0040, 64'h0000_0080_0000_0040, 1'b0, 2'd0, 32'h0, 1'b0},
      // R3 hv wins over virtual mode enable
      '{8'd3, 8'h01, 1'b1, 1'b1, 1'b0, 2'd0, 64'h0000_0000_0000_0010, 64'h0000_4000_0000_0010, 1'b0, 2'd0, 32'h0, 1'b0},
      // R6 1GB at limit, fetch
      '{8'd6, 8'h20, 1'b0, 1'b1, 1'b0, 2'd2, 64'h0000_0000_4000_0000, 64'h0, 1'b1, 2'd1, 32'h0800_0000, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic        hoff_we = 1'b0, goff_we = 1'b0;
   logic [63:0] hoff_wdata = '0, goff_wdata = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [63:0] req_ea = '0;
   logic        hv_state = 1'b0, hv_support = 1'b1;
   logic        ifetch_reloc = 1'b0, data_reloc = 1'b0, vseg_page_ok = 1'b0;
   logic        rsp_valid, rsp_fault, rsp_vseg;
   logic [63:0] rsp_ra;
   logic [1:0]  rsp_class;
   logic [31:0] rsp_status;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rmx_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .hoff_we(hoff_we), .hoff_wdata(hoff_wdata),
      .goff_we(goff_we), .goff_wdata(goff_wdata),
      .req_valid(req_valid), .req_kind(req_kind), .req_ea(req_ea),
      .hv_state(hv_state), .hv_support(hv_support),
      .ifetch_reloc(ifetch_reloc), .data_reloc(data_reloc),
      .vseg_page_ok(vseg_page_ok),
      .rsp_valid(rsp_valid), .rsp_ra(rsp_ra), .rsp_fault(rsp_fault),
      .rsp_class(rsp_class), .rsp_status(rsp_status), .rsp_vseg(rsp_vseg)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] flags();
      return {27'd0, rsp_valid, rsp_fault, rsp_class, rsp_status, rsp_vseg};
   endfunction

   function automatic logic [63:0] mk(logic v, logic f, logic [1:0] c, logic [31:0] s, logic vs);
      return {27'd0, v, f, c, s, vs};
   endfunction

   task automatic wr_ctl(input logic [7:0] v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v; req_valid = 1'b0;
   endtask

   // Present a request at the next falling edge; the response is checked one cycle later.
   task automatic issue(input logic [1:0] k, input logic [63:0] ea, input logic hv,
                        input logic hs, input logic pg);
      @(negedge clk);
      ctl_we = 1'b0;
      req_valid = 1'b1; req_kind = k; req_ea = ea;
      hv_state = hv; hv_support = hs; vseg_page_ok = pg;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 outputs idle during reset
      chk("R9 reset flags", flags(), mk(1'b0, 1'b0, 2'd0, 32'h0, 1'b0));
      chk("R9 reset ra", rsp_ra, 64'h0);
      rst_n = 1'b1;

      // R9 hypervisor offset is zero after reset
      issue(2'd0, 64'h0000_0000_0000_0055, 1'b1, 1'b1, 1'b0);
      chk("R9 zero hv offset", rsp_ra, 64'h55);
      // R9 decoded limit is zero after reset: guest load faults
      issue(2'd0, 64'h0, 1'b0, 1'b1, 1'b0);
      chk("R9 zero limit", flags(), mk(1'b1, 1'b1, 2'd2, 32'h0800_0000, 1'b0));

      @(negedge clk);
      hoff_we = 1'b1; hoff_wdata = HOFF; goff_we = 1'b1; goff_wdata = GOFF;
      @(negedge clk);
      hoff_we = 1'b0; goff_we = 1'b0;

      for (int i = 0; i < NV; i++) begin
         wr_ctl(VEC[i].ctl);
         issue(VEC[i].kind, VEC[i].ea, VEC[i].hv, VEC[i].hvsup, VEC[i].pgok);
         chk($sformatf("R%0d row %0d flags", VEC[i].req, i), flags(),
             mk(1'b1, VEC[i].xfault, VEC[i].xcls, VEC[i].xst, VEC[i].xvseg));
         chk($sformatf("R%0d row %0d ra", VEC[i].req, i), rsp_ra, VEC[i].xra);
      end

      // R8 write immediately followed by a request
      wr_ctl(8'h80);
      issue(2'd0, 64'h0000_0000_0300_0000, 1'b0, 1'b1, 1'b0);
      chk("R8 32MB fault", flags(), mk(1'b1, 1'b1, 2'd2, 32'h0800_0000, 1'b0));
      wr_ctl(8'h10);
      issue(2'd0, 64'h0000_0000_0300_0000, 1'b0, 1'b1, 1'b0);
      chk("R8 16GB pass", rsp_ra, 64'h0000_0080_0300_0000);
      chk("R8 16GB no fault", flags(), mk(1'b1, 1'b0, 2'd0, 32'h0, 1'b0));

      // R1 load with data relocation on: no strobe
      data_reloc = 1'b1;
      issue(2'd0, 64'h100, 1'b1, 1'b1, 1'b0);
      chk("R1 load reloc on", {63'd0, rsp_valid}, 64'd0);
      // R1 fetch ignores data relocation
      issue(2'd2, 64'h100, 1'b1, 1'b1, 1'b0);
      chk("R1 fetch reloc off", {63'd0, rsp_valid}, 64'd1);
      chk("R1 fetch ra", rsp_ra, 64'h0000_4000_0000_0100);
      data_reloc = 1'b0;
      ifetch_reloc = 1'b1;
      // R1 fetch with instruction relocation on: no strobe
      issue(2'd2, 64'h100, 1'b1, 1'b1, 1'b0);
      chk("R1 fetch reloc on", {63'd0, rsp_valid}, 64'd0);
      // R1 store ignores instruction relocation
      issue(2'd1, 64'h200, 1'b1, 1'b1, 1'b0);
      chk("R1 store strobe", {63'd0, rsp_valid}, 64'd1);
      ifetch_reloc = 1'b0;

      // R10 reserved kind: no strobe
      issue(2'd3, 64'h100, 1'b1, 1'b1, 1'b0);
      chk("R10 reserved kind", {63'd0, rsp_valid}, 64'd0);

      @(negedge clk);
      finish_run();
   end

endmodule